// File: doc/BRIEF.md
# Memory Interface Address Decoder

This block sits between a simple word-wide request bus and three kinds of target: a main memory array, a window of memory-device registers, and a handful of interface control registers. Each accepted request is classified by its byte address. Memory reads and writes are forwarded to a synchronous single-port memory port. Writes into the device register window are forwarded as one-cycle events, and reads from that window return zero. Accesses to the control registers are handled locally.

The memory space covers far more addresses than are populated. A read from the unpopulated part returns zero without error. A write there is rejected with an error and reaches no memory. The control group holds one read/write select register. The other control registers accept only fixed values, and any other value is answered with an error. Every request gets exactly one response one cycle after it is accepted. The error flag is a single-cycle pulse on that response.

Top module: `mem_if_decoder`

## Requirements
- R1: After reset, resp_valid and dev_wr_valid are low, and the select register at byte address 0x0400_000C reads back 0x0000_0014.
- R2: req_ready is always high. A request with req_valid high on a rising edge produces resp_valid high for exactly the following cycle. Without a request, resp_valid stays low.
- R3: A read at a byte address below 0x03F0_0000 whose word index addr[25:2] is below 2^MEM_AW drives mem_en in the request cycle with mem_addr equal to that index and mem_we low. The response carries mem_rdata without error.
- R4: A read below 0x03F0_0000 whose word index is at or above 2^MEM_AW returns zero without error and does not drive mem_en.
- R5: A write to a populated word index drives mem_en and mem_we in the request cycle, with the word index on mem_addr and the write data on mem_wdata. It responds without error.
- R6: A write below 0x03F0_0000 to an unpopulated word index does not drive mem_en and responds with resp_err high. Memory contents are left unchanged.
- R7: A write in 0x03F0_0000..0x03FF_FFFF responds without error and raises dev_wr_valid in the response cycle, with dev_wr_reg = addr[18:0], dev_wr_bcast = addr[19] and the write data. A read in that window returns zero without error and raises no event.
- R8: The select register (byte address 0x0400_000C) stores any written 32-bit value. It changes on no other access.
- R9: The fixed-value registers are checked on write: mode at 0x0400_0000 accepts 0x00 or 0x0E, config at 0x0400_0004 accepts 0x40, current-load at 0x0400_0008 accepts 0x00, and refresh at 0x0400_0010 accepts 0x0006_3634. Any other value responds with resp_err high. Refresh reads return zero without error.
- R10: Any other address raises resp_err and returns zero. This covers reads of mode, config and current-load, control offsets 0x14..0x1F, and everything at or above 0x0400_0000 outside 0x0400_0000..0x0400_0013. Address bits [1:0] are ignored throughout.
- R11: resp_rdata is zero on every write response and on every error response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response present, one cycle after acceptance |
| resp_rdata | output | DATA_W | Read data |
| resp_err | output | 1 | Error pulse aligned with the response |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | MEM_AW | Memory word index |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_en |
| dev_wr_valid | output | 1 | Device register write event |
| dev_wr_reg | output | 19 | Device register offset |
| dev_wr_bcast | output | 1 | Event is a broadcast write |
| dev_wr_data | output | DATA_W | Device register write data |

## Verification
The bench builds the decoder with MEM_AW = 8, so the populated memory is 256 words. Every populated word is written and read back. The boundary just above the populated size, and addresses spread through the large unpopulated part of the memory space, are then small enough to probe, including index aliasing back onto low words. With that size the fixed-value registers can also be swept over dense value ranges around their legal values. The device window is probed with and without the broadcast bit, and the control block's edges are probed one word at a time.

// File: rtl/mif_pkg.sv
package mif_pkg;

  // Classification of one request address
  typedef enum logic [2:0] {
    RG_MEM_LIVE,
    RG_MEM_VOID,
    RG_DEVWIN,
    RG_CTRL,
    RG_UNMAPPED
  } region_e;

  // Word slot inside the control block (addr[4:2]); order follows the address map
  typedef enum logic [2:0] {
    CI_MODE    = 3'd0,
    CI_CONFIG  = 3'd1,
    CI_LOAD    = 3'd2,
    CI_SELECT  = 3'd3,
    CI_REFRESH = 3'd4
  } ctrl_idx_e;

  localparam logic [31:0] MEMSPACE_END = 32'h03F0_0000;
  localparam logic [31:0] DEVWIN_END   = 32'h0400_0000;
  localparam logic [31:0] CTRL_BASE    = 32'h0400_0000;
  localparam logic [2:0]  CTRL_LAST    = 3'd4;

  localparam int SPACE_HI_BIT = 25;   // memory-space word index is addr[25:2]
  localparam int SPACE_IW     = 24;
  localparam int DEV_REG_W    = 19;
  localparam int DEV_BCAST_BIT = 19;

  localparam logic [31:0] MODE_OFF_VAL  = 32'h0000_0000;
  localparam logic [31:0] MODE_ON_VAL   = 32'h0000_000E;
  localparam logic [31:0] CONFIG_VAL    = 32'h0000_0040;
  localparam logic [31:0] LOAD_VAL      = 32'h0000_0000;
  localparam logic [31:0] REFRESH_VAL   = 32'h0006_3634;

endpackage

// File: rtl/mif_region_decode.sv
module mif_region_decode
  import mif_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MEM_AW = 21
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output ctrl_idx_e         cidx,
  output logic [MEM_AW-1:0] widx
);

  logic [SPACE_IW-1:0] space_idx;
  logic                live;
  logic                in_space;
  logic                in_dev;
  logic                in_ctrl;

  assign space_idx = addr[SPACE_HI_BIT:2];
  assign widx      = space_idx[MEM_AW-1:0];

  generate
    if (MEM_AW >= SPACE_IW) begin : g_full
      assign live = 1'b1;
    end else begin : g_part
      assign live = ~|space_idx[SPACE_IW-1:MEM_AW];
    end
  endgenerate

  assign in_space = (addr < MEMSPACE_END);
  assign in_dev   = !in_space && (addr < DEVWIN_END);
  assign in_ctrl  = (addr[ADDR_W-1:5] == CTRL_BASE[ADDR_W-1:5]) && (addr[4:2] <= CTRL_LAST);

  always_comb begin
    if (in_space)     region = live ? RG_MEM_LIVE : RG_MEM_VOID;
    else if (in_dev)  region = RG_DEVWIN;
    else if (in_ctrl) region = RG_CTRL;
    else              region = RG_UNMAPPED;
  end

  assign cidx = ctrl_idx_e'(addr[4:2]);

endmodule

// File: rtl/mif_ctrl_regs.sv
module mif_ctrl_regs
  import mif_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter logic [DATA_W-1:0] SELECT_INIT = 'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  ctrl_idx_e         cidx,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ok
);

  logic [DATA_W-1:0] sel_q;

  always_comb begin
    rd_ok   = 1'b0;
    rd_data = '0;
    wr_ok   = 1'b0;
    case (cidx)
      CI_MODE:    wr_ok = (wdata == DATA_W'(MODE_OFF_VAL)) || (wdata == DATA_W'(MODE_ON_VAL));
      CI_CONFIG:  wr_ok = (wdata == DATA_W'(CONFIG_VAL));
      CI_LOAD:    wr_ok = (wdata == DATA_W'(LOAD_VAL));
      CI_SELECT: begin
        wr_ok   = 1'b1;
        rd_ok   = 1'b1;
        rd_data = sel_q;
      end
      CI_REFRESH: begin
        wr_ok = (wdata == DATA_W'(REFRESH_VAL));
        rd_ok = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                              sel_q <= SELECT_INIT;
    else if (wr_en && cidx == CI_SELECT)  sel_q <= wdata;
  end

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && cidx == CI_SELECT) |=> $stable(sel_q));

endmodule

// File: rtl/mif_resp_stage.sv
module mif_resp_stage
  import mif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc,
  input  logic                 err_in,
  input  logic                 use_mem_in,
  input  logic [DATA_W-1:0]    local_in,
  input  logic                 dev_fire,
  input  logic [DEV_REG_W-1:0] dev_reg_in,
  input  logic                 dev_bcast_in,
  input  logic [DATA_W-1:0]    dev_data_in,
  output logic                 resp_valid,
  output logic                 resp_err,
  output logic                 use_mem_q,
  output logic [DATA_W-1:0]    local_q,
  output logic                 dev_valid,
  output logic [DEV_REG_W-1:0] dev_reg,
  output logic                 dev_bcast,
  output logic [DATA_W-1:0]    dev_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      use_mem_q  <= 1'b0;
      local_q    <= '0;
      dev_valid  <= 1'b0;
      dev_reg    <= '0;
      dev_bcast  <= 1'b0;
      dev_data   <= '0;
    end else begin
      resp_valid <= acc;
      resp_err   <= acc && err_in;
      use_mem_q  <= acc && use_mem_in;
      local_q    <= acc ? local_in : '0;
      dev_valid  <= acc && dev_fire;
      if (acc && dev_fire) begin
        dev_reg   <= dev_reg_in;
        dev_bcast <= dev_bcast_in;
        dev_data  <= dev_data_in;
      end
    end
  end

  // R7
  dev_event_ok_chk: assert property (@(posedge clk) disable iff (rst)
    dev_valid |-> (resp_valid && !resp_err && !use_mem_q));

endmodule

// File: rtl/mem_if_decoder.sv
module mem_if_decoder
  import mif_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter int                MEM_AW      = 21,
  parameter logic [DATA_W-1:0] SELECT_INIT = 'h14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 resp_valid,
  output logic [DATA_W-1:0]    resp_rdata,
  output logic                 resp_err,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [MEM_AW-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 dev_wr_valid,
  output logic [DEV_REG_W-1:0] dev_wr_reg,
  output logic                 dev_wr_bcast,
  output logic [DATA_W-1:0]    dev_wr_data
);

  localparam logic [ADDR_W:0] LIVE_BYTES = (ADDR_W+1)'(1) << (MEM_AW + 2);

  region_e           region;
  ctrl_idx_e         cidx;
  logic [MEM_AW-1:0] widx;
  logic              acc;
  logic              ctrl_rd_ok;
  logic              ctrl_wr_ok;
  logic [DATA_W-1:0] ctrl_rd_data;
  logic              err_now;
  logic [DATA_W-1:0] local_now;
  logic              use_mem_q;
  logic [DATA_W-1:0] local_q;

  assign req_ready = 1'b1;
  assign acc       = req_valid;

  mif_region_decode #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dec (
    .addr   (req_addr),
    .region (region),
    .cidx   (cidx),
    .widx   (widx)
  );

  mif_ctrl_regs #(.DATA_W(DATA_W), .SELECT_INIT(SELECT_INIT)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (acc && req_write && region == RG_CTRL && ctrl_wr_ok),
    .cidx    (cidx),
    .wdata   (req_wdata),
    .rd_ok   (ctrl_rd_ok),
    .rd_data (ctrl_rd_data),
    .wr_ok   (ctrl_wr_ok)
  );

  // memory port: driven in the request cycle, data returns one cycle later
  assign mem_en    = acc && (region == RG_MEM_LIVE);
  assign mem_we    = mem_en && req_write;
  assign mem_addr  = widx;
  assign mem_wdata = req_wdata;

  always_comb begin
    err_now   = 1'b0;
    local_now = '0;
    unique case (region)
      RG_MEM_LIVE: ;
      RG_MEM_VOID: err_now = req_write;
      RG_DEVWIN:   ;
      RG_CTRL: begin
        if (req_write) err_now = !ctrl_wr_ok;
        else begin
          err_now   = !ctrl_rd_ok;
          local_now = ctrl_rd_data;
        end
      end
      default:     err_now = 1'b1;
    endcase
  end

  mif_resp_stage #(.DATA_W(DATA_W)) u_resp (
    .clk          (clk),
    .rst          (rst),
    .acc          (acc),
    .err_in       (err_now),
    .use_mem_in   (!req_write && region == RG_MEM_LIVE),
    .local_in     (local_now),
    .dev_fire     (req_write && region == RG_DEVWIN),
    .dev_reg_in   (req_addr[DEV_REG_W-1:0]),
    .dev_bcast_in (req_addr[DEV_BCAST_BIT]),
    .dev_data_in  (req_wdata),
    .resp_valid   (resp_valid),
    .resp_err     (resp_err),
    .use_mem_q    (use_mem_q),
    .local_q      (local_q),
    .dev_valid    (dev_wr_valid),
    .dev_reg      (dev_wr_reg),
    .dev_bcast    (dev_wr_bcast),
    .dev_data     (dev_wr_data)
  );

  assign resp_rdata = use_mem_q ? mem_rdata : local_q;

  // R2
  one_resp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  // R2
  no_spur_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);

  // R4
  mem_live_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> ({1'b0, req_addr} < LIVE_BYTES));

  // R5
  mem_we_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_en && req_write));

  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_err) |-> (resp_rdata == '0));

  // R6
  void_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr < MEMSPACE_END && {1'b0, req_addr} >= LIVE_BYTES)
      |-> (!mem_en ##1 resp_err));

endmodule

// File: tb/tb_mem_if_decoder.sv
`timescale 1ns/1ps
module tb_mem_if_decoder;

  localparam int AW = 8;
  localparam int WORDS = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        resp_err;
  logic        mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        dev_wr_valid;
  logic [18:0] dev_wr_reg;
  logic        dev_wr_bcast;
  logic [31:0] dev_wr_data;

  always #2.5 clk = ~clk;

  mem_if_decoder #(.MEM_AW(AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_wr_valid(dev_wr_valid), .dev_wr_reg(dev_wr_reg),
    .dev_wr_bcast(dev_wr_bcast), .dev_wr_data(dev_wr_data)
  );

  // synchronous memory model
  logic [31:0] ram [WORDS];
  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic s_en, s_we;
  logic [AW-1:0] s_maddr;
  logic [31:0] s_mwdata;
  logic r_valid, r_err, r_dv, r_db;
  logic [31:0] r_data, r_dd;
  logic [18:0] r_dreg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic w, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    s_en = mem_en; s_we = mem_we; s_maddr = mem_addr; s_mwdata = mem_wdata;
    @(negedge clk);
    req_valid = 1'b0;
    r_valid = resp_valid; r_data = resp_rdata; r_err = resp_err;
    r_dv = dev_wr_valid; r_dreg = dev_wr_reg; r_db = dev_wr_bcast; r_dd = dev_wr_data;
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  task automatic fixed_wr(input string tag, input logic [31:0] a, input logic [31:0] v, input logic ok);
    xact(1'b1, a, v);
    chk({tag, " err"}, 32'(r_err), 32'(!ok));
    chk({tag, " rdata"}, r_data, 32'h0);
  endtask

  logic [31:0] sel_exp;

  initial begin
    for (int i = 0; i < WORDS; i++) ram[i] = 32'hDEAD_0000 | 32'(i);
    repeat (3) @(negedge clk);
    chk("R1 resp_valid in reset", 32'(resp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 resp_valid after reset", 32'(resp_valid), 0);
    chk("R1 dev_wr_valid after reset", 32'(dev_wr_valid), 0);
    chk("R2 ready", 32'(req_ready), 1);
    xact(1'b0, 32'h0400_000C, 0);
    chk("R1 select reset value", r_data, 32'h14);
    chk("R2 resp_valid", 32'(r_valid), 1);
    @(negedge clk);
    chk("R2 no response when idle", 32'(resp_valid), 0);

    // R5: fill all populated words
    for (int i = 0; i < WORDS; i++) begin
      xact(1'b1, 32'(i) << 2 | 32'(i % 4), pat(i));
      chk("R5 mem_en/we", {30'd0, s_en, s_we}, 32'd3);
      chk("R5 mem_addr", 32'(s_maddr), 32'(i));
      chk("R5 mem_wdata", s_mwdata, pat(i));
      chk("R5 err", 32'(r_err), 0);
      chk("R11 write rdata zero", r_data, 0);
    end
    // R3: read back
    for (int i = 0; i < WORDS; i++) begin
      xact(1'b0, 32'(i) << 2, 0);
      chk("R3 mem_en/we", {30'd0, s_en, s_we}, 32'd2);
      chk("R3 mem_addr", 32'(s_maddr), 32'(i));
      chk("R3 read data", r_data, pat(i));
      chk("R3 err", 32'(r_err), 0);
    end

    // R4/R6: unpopulated memory space
    for (int k = 0; k < 36; k++) begin
      logic [31:0] a;
      if (k < 32)       a = 32'h400 + 32'(k) * 32'h001F_0000;
      else if (k == 32) a = 32'h0000_0404;
      else if (k == 33) a = 32'h0080_0000;
      else if (k == 34) a = 32'h0100_0000;
      else              a = 32'h03EF_FFFC;
      xact(1'b0, a, 0);
      chk("R4 void read no mem_en", 32'(s_en), 0);
      chk("R4 void read data", r_data, 0);
      chk("R4 void read err", 32'(r_err), 0);
      xact(1'b1, a, 32'hFFFF_FFFF);
      chk("R6 void write no mem_en", 32'(s_en), 0);
      chk("R6 void write err", 32'(r_err), 1);
      chk("R11 err rdata zero", r_data, 0);
    end
    for (int i = 0; i < WORDS; i++) begin
      xact(1'b0, 32'(i) << 2, 0);
      chk("R6 memory unchanged", r_data, pat(i));
    end

    // R7: device register window
    for (int k = 0; k < 16; k++) begin
      logic [31:0] a;
      a = (k == 15) ? 32'h03FF_FFFC : 32'h03F0_0000 + 32'(k) * 32'h0001_1004;
      xact(1'b1, a, pat(k + 7));
      chk("R7 dev event", 32'(r_dv), 1);
      chk("R7 dev reg", 32'(r_dreg), a & 32'h0007_FFFF);
      chk("R7 dev bcast", 32'(r_db), 32'(a[19]));
      chk("R7 dev data", r_dd, pat(k + 7));
      chk("R7 dev write err", 32'(r_err), 0);
      chk("R7 no mem access", 32'(s_en), 0);
      xact(1'b0, a, 0);
      chk("R7 dev read zero", r_data, 0);
      chk("R7 dev read no event", 32'(r_dv), 0);
      chk("R7 dev read err", 32'(r_err), 0);
    end

    // R8: select register
    sel_exp = 32'h14;
    for (int k = 0; k < 8; k++) begin
      sel_exp = 32'h1 << (k * 4) ^ pat(k);
      xact(1'b1, 32'h0400_000C, sel_exp);
      chk("R8 select write err", 32'(r_err), 0);
      xact(1'b0, 32'h0400_000D, 0);
      chk("R8 select readback", r_data, sel_exp);
    end

    // R9: fixed-value registers
    for (int v = 0; v < 32; v++)
      fixed_wr("R9 mode", 32'h0400_0000, 32'(v), (v == 0) || (v == 14));
    for (int v = 56; v < 73; v++)
      fixed_wr("R9 config", 32'h0400_0004, 32'(v), v == 64);
    for (int v = 0; v < 8; v++)
      fixed_wr("R9 load", 32'h0400_0008, 32'(v), v == 0);
    fixed_wr("R9 refresh ok", 32'h0400_0010, 32'h0006_3634, 1'b1);
    fixed_wr("R9 refresh bad", 32'h0400_0010, 32'h0006_3635, 1'b0);
    fixed_wr("R9 refresh zero", 32'h0400_0010, 32'h0, 1'b0);
    fixed_wr("R9 refresh bad2", 32'h0400_0010, 32'h0006_3630, 1'b0);
    xact(1'b0, 32'h0400_0010, 0);
    chk("R9 refresh read data", r_data, 0);
    chk("R9 refresh read err", 32'(r_err), 0);
    xact(1'b0, 32'h0400_000C, 0);
    chk("R9 select untouched", r_data, sel_exp);

    // R10: unmapped and write-only
    for (int k = 0; k < 11; k++) begin
      logic [31:0] a;
      case (k)
        0: a = 32'h0400_0014;  1: a = 32'h0400_0018;  2: a = 32'h0400_001C;
        3: a = 32'h0400_0020;  4: a = 32'h0410_0000;  5: a = 32'h0500_0000;
        6: a = 32'h8000_0000;  7: a = 32'hFFFF_FFFC;  8: a = 32'h0400_0000;
        9: a = 32'h0400_0004;  default: a = 32'h0400_0008;
      endcase
      xact(1'b0, a, 0);
      chk("R10 read err", 32'(r_err), 1);
      chk("R10 read data zero", r_data, 0);
      chk("R10 no mem access", 32'(s_en), 0);
      if (k < 8) begin
        xact(1'b1, a, 32'h0000_0040);
        chk("R10 write err", 32'(r_err), 1);
        chk("R10 no dev event", 32'(r_dv), 0);
      end
    end
    xact(1'b0, 32'h0400_000C, 0);
    chk("R10 select untouched", r_data, sel_exp);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule